// File: doc/BRIEF.md
# Two-Wire Random-Read Master Sequencer

This block is a two-wire serial bus master that reads one byte from a memory-style slave as a single, uninterrupted operation. A one-cycle start pulse hands it a 7-bit device address and an 8-bit word address. It first sends the word address in transmit mode. It then turns the bus around with a repeated START and reads one data byte back in receive mode. No STOP is placed between the two phases, so the bus stays owned by this master throughout. Another master therefore cannot move the slave's internal address pointer between the pointer write and the data read.

Both lines are open-drain. The block only ever pulls a line low or lets it go. SCL is produced from a parameterised divider: every symbol on the bus (a bit, START, repeated START or STOP) is four quarter phases of `QDIV` clock cycles each. When the operation ends, a one-cycle `done` pulse is raised together with the byte read and an error flag. The error flag reports that the slave failed to acknowledge one of its three acknowledge slots. In that case the master ends the transfer early with a STOP.

Top module: `i2c_rr_master`

## Requirements
- R1: After reset, and at any time `busy` is low, the block drives neither line low; after reset `busy`, `done` and `nack_err` are 0 and `rd_data` is 0.
- R2: While SCL is released, SDA changes only to form a START or repeated START (SDA falls) or a STOP (SDA rises).
- R3: A full operation puts on the bus, in this order: START; the address byte {dev_addr, 0} sent MSB first; an acknowledge slot; word_addr sent MSB first; an acknowledge slot; repeated START; {dev_addr, 1}; an acknowledge slot; eight data bits; a master acknowledge slot; STOP. There is no STOP before the repeated START. SDA low in an acknowledge slot means acknowledge.
- R4: When `done` pulses with `nack_err` 0, `rd_data` holds the eight bits read, with the first bit received as bit 7.
- R5: In the acknowledge slot after the data byte, the master leaves SDA released (not-acknowledge).
- R6: If SDA is high in any of the three slave acknowledge slots, the next bus condition is STOP and `done` pulses with `nack_err` 1. In that case `rd_data` keeps its previous value. `nack_err` returns to 0 when the next `go` is accepted.
- R7: `busy` is high in the cycle after an accepted `go`. `done` is high for exactly one cycle, and `busy` is already low in that cycle.
- R8: A `go` pulse while `busy` is high is ignored: the running operation completes unchanged and no further operation starts.
- R9: During every data or acknowledge bit, SCL stays released for exactly 2*QDIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | One-cycle request to start an operation (taken only when idle) |
| dev_addr | input | 7 | Slave device address |
| word_addr | input | 8 | Location inside the slave to read |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| nack_err | output | 1 | The last operation ended on a missing slave acknowledge |
| rd_data | output | 8 | Byte returned by the last successful operation |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level seen on the SDA wire |

## Verification
A sequencer that advances wrongly shows up on the bus within one symbol, which is four quarters. Examples are a skipped acknowledge, a STOP where the repeated START belongs, or a bit counted one too few or too many. The bus monitor compares each START, STOP and bit as it appears, so the mismatch is reported at the first wrong event rather than only at `done`. A fault in the quarter timing or in the line-drive table shows up within one SCL high period. It appears either as a wrong high time or as SDA moving while SCL is high. A wrong sampling point or a wrong shift direction is only visible at `done`, as a wrong `rd_data` or a wrong `nack_err`.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;

  localparam int DEV_W  = 7;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  // Bus symbols; each occupies four quarter phases.
  typedef enum logic [2:0] {
    SYM_START,
    SYM_RSTART,
    SYM_STOP,
    SYM_WBIT,
    SYM_RBIT
  } sym_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WBYTE,
    ST_WACK,
    ST_RSTART,
    ST_RBYTE,
    ST_MNACK,
    ST_STOP
  } seq_e;

  // Address byte: device address above the direction bit (1 = read).
  function automatic logic [BYTE_W-1:0] addr_byte(logic [DEV_W-1:0] dev, logic rnw);
    return {dev, rnw};
  endfunction

  // Line drive for one quarter: {scl_low, sda_low}.
  function automatic logic [1:0] bus_drive(sym_e s, logic b, logic [1:0] q);
    logic [1:0] r;
    r = 2'b00;
    case (s)
      SYM_START: begin
        case (q)
          2'd0:    r = 2'b00;
          2'd1:    r = 2'b01;
          2'd2:    r = 2'b01;
          default: r = 2'b11;
        endcase
      end
      SYM_RSTART: begin
        case (q)
          2'd0:    r = 2'b10;
          2'd1:    r = 2'b00;
          2'd2:    r = 2'b01;
          default: r = 2'b11;
        endcase
      end
      SYM_STOP: begin
        case (q)
          2'd0:    r = 2'b11;
          2'd1:    r = 2'b01;
          default: r = 2'b00;
        endcase
      end
      SYM_WBIT: r = {(q == 2'd0) || (q == 2'd3), ~b};
      SYM_RBIT: r = {(q == 2'd0) || (q == 2'd3), 1'b0};
      default:  r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rr_qtick.sv
module rr_qtick #(
  parameter int QDIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (QDIV <= 1) begin : g_every
      assign tick = en;
    end else begin : g_count
      localparam int CW = $clog2(QDIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n || !en)              cnt_q <= '0;
        else if (cnt_q == CW'(QDIV-1))  cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
      end
      assign tick = en && (cnt_q == CW'(QDIV-1));
    end
  endgenerate
endmodule

// File: rtl/rr_bitphy.sv
module rr_bitphy
  import i2c_rr_pkg::*;
#(
  parameter int QDIV        = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  sym_e req_sym,
  input  logic req_bit,
  output logic active,
  output logic sym_done,
  output logic rbit,
  output logic scl_low,
  output logic sda_low,
  input  logic sda_in
);
  logic       active_q;
  logic [1:0] qc_q;
  sym_e       sym_q;
  logic       bit_q;
  logic       scl_low_q, sda_low_q;
  logic       rbit_q;
  logic       tick;
  logic       sda_s;
  logic [1:0] drive_now;

  // Input synchroniser, depth chosen by parameter.
  logic [SYNC_STAGES:0] chain;
  assign chain[0] = sda_in;
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g+1] <= 1'b1;
        else        chain[g+1] <= chain[g];
      end
    end
  endgenerate
  assign sda_s = chain[SYNC_STAGES];

  rr_qtick #(.QDIV(QDIV)) u_qtick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (active_q),
    .tick (tick)
  );

  assign drive_now = bus_drive(sym_q, bit_q, qc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      qc_q      <= 2'd0;
      sym_q     <= SYM_STOP;
      bit_q     <= 1'b1;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      rbit_q    <= 1'b1;
    end else begin
      if (req && !active_q) begin
        sym_q    <= req_sym;
        bit_q    <= req_bit;
        qc_q     <= 2'd0;
        active_q <= 1'b1;
      end
      if (active_q) begin
        {scl_low_q, sda_low_q} <= drive_now;
        if (tick) begin
          if (qc_q == 2'd1) rbit_q <= sda_s;
          if (qc_q == 2'd3) active_q <= 1'b0;
          else              qc_q <= qc_q + 2'd1;
        end
      end
    end
  end

  assign active   = active_q;
  assign sym_done = active_q && tick && (qc_q == 2'd3);
  assign rbit     = rbit_q;
  assign scl_low  = scl_low_q;
  assign sda_low  = sda_low_q;

  AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low_q && !$past(scl_low_q) && (sda_low_q != $past(sda_low_q)))
      |-> ($past(sym_q) == SYM_START || $past(sym_q) == SYM_RSTART || $past(sym_q) == SYM_STOP))
    else $error("SDA moved under high SCL outside a bus condition"); // R2

  AST_SYMBOL_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_done |=> !active_q)
    else $error("symbol did not end after its fourth quarter"); // R9
endmodule

// File: rtl/rr_seq.sv
module rr_seq
  import i2c_rr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic [BYTE_W-1:0] word_addr,
  input  logic              phy_active,
  input  logic              sym_done,
  input  logic              rbit,
  output logic              req,
  output sym_e              req_sym,
  output logic              req_bit,
  output logic              busy,
  output logic              done,
  output logic              nack_err,
  output logic [BYTE_W-1:0] rd_data
);
  seq_e              state_q;
  logic              pending_q;
  logic [DEV_W-1:0]  dev_q;
  logic [BYTE_W-1:0] word_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] rd_q;
  logic [BIT_CW-1:0] bitc_q;
  logic [1:0]        idx_q;
  logic              done_q, err_q;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next = {rx_q[BYTE_W-2:0], rbit};

  // Symbol requested in each state.
  always_comb begin
    req_sym = SYM_STOP;
    req_bit = 1'b1;
    case (state_q)
      ST_START:  req_sym = SYM_START;
      ST_WBYTE:  begin req_sym = SYM_WBIT; req_bit = sh_q[BYTE_W-1]; end
      ST_WACK:   req_sym = SYM_RBIT;
      ST_RSTART: req_sym = SYM_RSTART;
      ST_RBYTE:  req_sym = SYM_RBIT;
      ST_MNACK:  begin req_sym = SYM_WBIT; req_bit = 1'b1; end
      default:   req_sym = SYM_STOP;
    endcase
  end

  assign req = (state_q != ST_IDLE) && !pending_q && !phy_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pending_q <= 1'b0;
      dev_q     <= '0;
      word_q    <= '0;
      sh_q      <= '0;
      rx_q      <= '0;
      rd_q      <= '0;
      bitc_q    <= '0;
      idx_q     <= 2'd0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (req) pending_q <= 1'b1;
      if (state_q == ST_IDLE) begin
        if (go) begin
          dev_q   <= dev_addr;
          word_q  <= word_addr;
          err_q   <= 1'b0;
          state_q <= ST_START;
        end
      end else if (sym_done) begin
        pending_q <= 1'b0;
        case (state_q)
          ST_START: begin
            sh_q    <= addr_byte(dev_q, 1'b0);
            bitc_q  <= BIT_CW'(BYTE_W-1);
            idx_q   <= 2'd0;
            state_q <= ST_WBYTE;
          end
          ST_WBYTE: begin
            if (bitc_q == '0) state_q <= ST_WACK;
            else begin
              bitc_q <= bitc_q - 1'b1;
              sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
          ST_WACK: begin
            if (rbit) begin
              err_q   <= 1'b1;
              state_q <= ST_STOP;
            end else if (idx_q == 2'd0) begin
              sh_q    <= word_q;
              bitc_q  <= BIT_CW'(BYTE_W-1);
              idx_q   <= 2'd1;
              state_q <= ST_WBYTE;
            end else if (idx_q == 2'd1) begin
              state_q <= ST_RSTART;
            end else begin
              bitc_q  <= BIT_CW'(BYTE_W-1);
              state_q <= ST_RBYTE;
            end
          end
          ST_RSTART: begin
            sh_q    <= addr_byte(dev_q, 1'b1);
            bitc_q  <= BIT_CW'(BYTE_W-1);
            idx_q   <= 2'd2;
            state_q <= ST_WBYTE;
          end
          ST_RBYTE: begin
            rx_q <= rx_next;
            if (bitc_q == '0) begin
              rd_q    <= rx_next;
              state_q <= ST_MNACK;
            end else bitc_q <= bitc_q - 1'b1;
          end
          ST_MNACK: state_q <= ST_STOP;
          default: begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        endcase
      end
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign nack_err = err_q;
  assign rd_data  = rd_q;

  AST_NACK_GOES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_done && state_q == ST_WACK && rbit) |=> (state_q == ST_STOP && err_q))
    else $error("missing acknowledge not followed by STOP"); // R6

  AST_WORD_ACK_TO_RSTART: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_done && state_q == ST_WACK && !rbit && idx_q == 2'd1) |=> (state_q == ST_RSTART))
    else $error("word address not followed by repeated START"); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done longer than one cycle"); // R7

  AST_GO_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> ($stable(dev_q) && $stable(word_q)))
    else $error("request taken while busy"); // R8
endmodule

// File: rtl/i2c_rr_master.sv
module i2c_rr_master
  import i2c_rr_pkg::*;
#(
  parameter int QDIV        = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [6:0] dev_addr,
  input  logic [7:0] word_addr,
  output logic       busy,
  output logic       done,
  output logic       nack_err,
  output logic [7:0] rd_data,
  output logic       scl_low,
  output logic       sda_low,
  input  logic       sda_in
);
  logic phy_active, sym_done, rbit, req, req_bit;
  sym_e req_sym;

  rr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .dev_addr  (dev_addr),
    .word_addr (word_addr),
    .phy_active(phy_active),
    .sym_done  (sym_done),
    .rbit      (rbit),
    .req       (req),
    .req_sym   (req_sym),
    .req_bit   (req_bit),
    .busy      (busy),
    .done      (done),
    .nack_err  (nack_err),
    .rd_data   (rd_data)
  );

  rr_bitphy #(.QDIV(QDIV), .SYNC_STAGES(SYNC_STAGES)) u_phy (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .req_sym (req_sym),
    .req_bit (req_bit),
    .active  (phy_active),
    .sym_done(sym_done),
    .rbit    (rbit),
    .scl_low (scl_low),
    .sda_low (sda_low),
    .sda_in  (sda_in)
  );

  AST_BUS_FREE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low))
    else $error("line held while idle"); // R1
endmodule

// File: tb/i2c_rr_master_bench.sv
module i2c_rr_master_bench;
  localparam int QD = 4;
  localparam logic [6:0] SLV_DEV = 7'h50;
  localparam int EV_START = 2;
  localparam int EV_STOP  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go_i = 1'b0;
  logic [6:0] dev_i = '0;
  logic [7:0] word_i = '0;
  logic busy, done, nack_err, scl_low, sda_low;
  logic [7:0] rd_data;
  logic s_drive = 1'b0;
  logic sda_bus, scl_bus;

  assign sda_bus = !(sda_low || s_drive);
  assign scl_bus = !scl_low;

  always #10 clk = ~clk;

  i2c_rr_master #(.QDIV(QD)) u_i2c_rr_master (
    .clk(clk), .rst_n(rst_n), .go(go_i), .dev_addr(dev_i), .word_addr(word_i),
    .busy(busy), .done(done), .nack_err(nack_err), .rd_data(rd_data),
    .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_bus)
  );

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  int exp_ev[$];
  string exp_rq[$];
  logic [7:0] exp_data[$];
  logic exp_err[$];
  logic [7:0] mem [16];
  logic [7:0] last_good = 8'h00;
  int nack_slot = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic push_ev(input int ev, input string rq);
    exp_ev.push_back(ev);
    exp_rq.push_back(rq);
  endtask

  task automatic push_byte(input logic [7:0] b, input string rq);
    for (int i = 7; i >= 0; i--) push_ev(int'(b[i]), rq);
  endtask

  task automatic log_ev(input int ev);
    if (exp_ev.size() == 0) chk(1'b0, "R3 unexpected bus event", ev, -1);
    else begin
      int e;
      string r;
      e = exp_ev.pop_front();
      r = exp_rq.pop_front();
      chk(ev == e, r, ev, e);
    end
  endtask

  // Behavioural slave and bus monitor.
  logic prev_scl = 1'b1, prev_sda = 1'b1, pend_valid = 1'b0, pend_bit = 1'b0;
  logic rise_seen = 1'b0, acked = 1'b0, prev_done = 1'b0;
  int hi_cnt = 0, nb = 0, mode = 0, phase = 0;
  logic [7:0] sh = '0, tx = '0;
  logic [3:0] ptr = '0;

  task automatic slave_start();
    mode = 1; nb = 0; phase = 0; s_drive = 1'b0;
  endtask

  task automatic slave_bit(input logic b);
    int cur;
    if (mode == 1) begin
      nb++;
      if (nb <= 8) sh = {sh[6:0], b};
      if (nb == 8) begin
        cur = (phase == 0) ? (sh[0] ? 3 : 1) : 2;
        acked = ((phase == 0) ? (sh[7:1] == SLV_DEV) : (phase == 1)) && (nack_slot != cur);
        s_drive = acked;
      end else if (nb == 9) begin
        s_drive = 1'b0;
        nb = 0;
        if (!acked) mode = 0;
        else if (phase == 0 && !sh[0]) phase = 1;
        else if (phase == 0 && sh[0]) begin
          mode = 2; tx = mem[ptr]; s_drive = !tx[7];
        end else if (phase == 1) begin
          ptr = sh[3:0]; phase = 2;
        end
      end
    end else if (mode == 2) begin
      nb++;
      if (nb < 8) s_drive = !tx[7-nb];
      else if (nb == 8) s_drive = 1'b0;
      else mode = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_bus && !prev_scl) begin
        pend_valid = 1'b1; pend_bit = sda_bus; hi_cnt = 1; rise_seen = 1'b1;
      end else if (scl_bus && prev_scl) begin
        hi_cnt++;
        if (prev_sda && !sda_bus) begin
          log_ev(EV_START); pend_valid = 1'b0; rise_seen = 1'b0; slave_start();
        end else if (!prev_sda && sda_bus) begin
          log_ev(EV_STOP); pend_valid = 1'b0; rise_seen = 1'b0; mode = 0; s_drive = 1'b0;
        end
      end else if (!scl_bus && prev_scl) begin
        if (rise_seen) chk(hi_cnt == 2*QD, "R9 SCL high time", hi_cnt, 2*QD);
        rise_seen = 1'b0;
        if (pend_valid) begin log_ev(int'(pend_bit)); slave_bit(pend_bit); end
        pend_valid = 1'b0;
      end
      if (done) begin
        chk(!prev_done, "R7 done width", 1, 0);
        chk(!busy, "R7 busy low with done", int'(busy), 0);
        if (exp_data.size() > 0) begin
          logic [7:0] ed;
          logic ee;
          ed = exp_data.pop_front();
          ee = exp_err.pop_front();
          chk(rd_data == ed, "R4 rd_data", int'(rd_data), int'(ed));
          chk(nack_err == ee, "R6 nack_err", int'(nack_err), int'(ee));
        end else chk(1'b0, "R8 unexpected done", 1, 0);
        chk(exp_ev.size() == 0, "R3 events left at done", exp_ev.size(), 0);
        done_cnt++;
      end
      prev_done = done;
      prev_scl = scl_bus;
      prev_sda = sda_bus;
    end
  end

  // Driver: builds the expected bus trace and result, then starts the operation.
  task automatic run_op(input logic [6:0] dev, input logic [7:0] word, input int slot, input bit poke);
    int target;
    bit fail1, fail2, fail3;
    fail1 = (dev != SLV_DEV) || (slot == 1);
    fail2 = (slot == 2);
    fail3 = (slot == 3);
    push_ev(EV_START, "R2 START");
    push_byte({dev, 1'b0}, "R3 write address");
    if (fail1) begin
      push_ev(1, "R6 nack slot"); push_ev(EV_STOP, "R6 STOP after nack");
    end else begin
      push_ev(0, "R3 ack");
      push_byte(word, "R3 word address");
      if (fail2) begin
        push_ev(1, "R6 nack slot"); push_ev(EV_STOP, "R6 STOP after nack");
      end else begin
        push_ev(0, "R3 ack");
        push_ev(EV_START, "R2 repeated START, no STOP between phases");
        push_byte({dev, 1'b1}, "R3 read address");
        if (fail3) begin
          push_ev(1, "R6 nack slot"); push_ev(EV_STOP, "R6 STOP after nack");
        end else begin
          push_ev(0, "R3 ack");
          push_byte(mem[word[3:0]], "R4 data bits");
          push_ev(1, "R5 master nack");
          push_ev(EV_STOP, "R2 STOP");
        end
      end
    end
    if (fail1 || fail2 || fail3) begin
      exp_data.push_back(last_good); exp_err.push_back(1'b1);
    end else begin
      last_good = mem[word[3:0]];
      exp_data.push_back(last_good); exp_err.push_back(1'b0);
    end
    nack_slot = slot;
    target = done_cnt + 1;
    @(negedge clk);
    dev_i = dev; word_i = word; go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    chk(busy, "R7 busy after go", int'(busy), 1);
    if (poke) begin
      repeat (150) @(negedge clk);
      dev_i = 7'h11; word_i = 8'h07; go_i = 1'b1;
      @(negedge clk);
      go_i = 1'b0;
    end
    while (done_cnt < target) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(!busy, "R8 idle after done", int'(busy), 0);
    chk(scl_bus && sda_bus, "R1 lines free when idle", int'({scl_bus, sda_bus}), 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 8'h3B) ^ 8'hC6;
    mem[0]  = 8'hFF;
    mem[15] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(scl_bus && sda_bus, "R1 lines released", int'({scl_bus, sda_bus}), 3);
    chk(!busy && !done && !nack_err, "R1 flags", int'({busy, done, nack_err}), 0);
    chk(rd_data == 8'h00, "R1 rd_data", int'(rd_data), 0);
    run_op(SLV_DEV, 8'h03, 0, 1'b0);
    run_op(SLV_DEV, 8'h0A, 0, 1'b0);
    run_op(SLV_DEV, 8'h00, 0, 1'b0);  // all-ones byte
    run_op(SLV_DEV, 8'hFF, 0, 1'b0);  // all-zeros byte
    run_op(7'h21, 8'h05, 0, 1'b0);    // R6: wrong device, first slot
    run_op(SLV_DEV, 8'h05, 2, 1'b0);  // R6: word slot
    run_op(SLV_DEV, 8'h05, 3, 1'b0);  // R6: read address slot
    run_op(SLV_DEV, 8'h06, 0, 1'b1);  // R8: go while busy, R6 flag cleared
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule